// File: doc/BRIEF.md
# Round-Robin Input Dispatcher with Credit Gating

This block is the first stage of a multistage packet switch. It has one packet queue for each of its input ports and the same number of outgoing links, one for each central module. Every queue has its own link selector. The selectors come out of reset holding distinct link indices, and all of them step forward by one position every cycle. Because they move in lockstep, no two queues ever aim at the same link in the same cycle, and no request and grant matching is needed.

A queue sends its head packet only when the targeted link still holds downstream credit. Each link keeps a credit counter. The counter starts at the downstream ingress buffer depth, loses one per packet sent and gains one per returned credit pulse. A fixed-dispatch mode ties queue r to link r. This keeps every flow on one path and so in order. A packet is a single fixed-width word.

Top module: `rr_input_dispatcher`

## Requirements
- R1: After reset, all queues are empty, every `link_valid_o` bit is 0, every `overflow_o` bit is 0, selector r holds index r, and every link counter holds CREDIT_MAX.
- R2: With `fixed_mode_i` = 0, in the s-th cycle after reset release (s = 0 first), queue r offers its head on link (r + s) mod NUM_PORTS. No link is ever claimed by two queues.
- R3: Every selector advances by one, modulo NUM_PORTS, on every cycle. This happens whether its queue is empty, blocked by credit, or in fixed mode.
- R4: A queue takes at most one packet per cycle and sends at most one per cycle, in arrival order. A packet written in cycle t can leave in cycle t+1 at the earliest.
- R5: A link sends only while its counter is nonzero. The counter drops by one per send and rises by one per `credit_i` pulse. A packet that is refused stays at the head of its queue.
- R6: With `fixed_mode_i` = 1, queue r uses only link r.
- R7: A write to a queue that holds FIFO_DEPTH packets at that edge is dropped, even if a packet leaves in the same cycle. The write sets `overflow_o[r]`, which then stays 1 until reset.
- R8: Lane l of `link_data_o` (bits l*DATA_W and up) carries the head packet of the queue that sends on link l. It reads zero while `link_valid_o[l]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one slot per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fixed_mode_i | input | 1 | 1: queue r to link r; 0: rotating dispatch |
| in_valid_i | input | NUM_PORTS | Write strobe per input port |
| in_data_i | input | NUM_PORTS*DATA_W | Packet word per input port |
| credit_i | input | NUM_PORTS | Credit return pulse per link |
| link_valid_o | output | NUM_PORTS | Packet sent on link this cycle |
| link_data_o | output | NUM_PORTS*DATA_W | Packet word per link |
| overflow_o | output | NUM_PORTS | Sticky drop flag per queue |

## Verification
The hardest case to reach is a stall and a rotation happening together. A head packet is refused for lack of credit while its selector keeps moving. The packet must then leave later, on whatever link the rotation names at that moment, without two queues ever colliding. The stimulus gets there in three ways. It withholds credit returns so that links run dry. It keeps writing until queues fill and overflow. It toggles the mode mid-stream. Credits come back at random only against packets actually outstanding, so counters touch zero often while the rotation runs on.

// File: rtl/rid_pkg.sv
`timescale 1ns/1ps
package rid_pkg;
  typedef enum logic {
    MODE_ROTATE = 1'b0,
    MODE_FIXED  = 1'b1
  } disp_mode_e;

  function automatic int unsigned idx_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rid_selector.sv
`timescale 1ns/1ps
module rid_selector #(
  parameter int unsigned NUM   = 4,
  parameter int unsigned START = 0,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [IDX_W-1:0] sel_o
);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ptr_q <= IDX_W'(START);
    else if (ptr_q == IDX_W'(NUM - 1))    ptr_q <= '0;
    else                                  ptr_q <= ptr_q + 1'b1;
  end

  assign sel_o = ptr_q;
endmodule

// File: rtl/rid_fifo.sv
`timescale 1ns/1ps
module rid_fifo #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              busy_o,
  output logic              ovf_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     rd_q, wr_q;
  logic [CW-1:0]     cnt_q;
  logic              full, do_wr, do_rd, ovf_q;

  assign full  = (cnt_q == CW'(DEPTH));
  assign do_wr = push_i && !full;
  assign do_rd = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (do_wr) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_rd) rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (push_i && full) ovf_q <= 1'b1;
    end
  end

  assign head_o = mem_q[rd_q];
  assign busy_o = (cnt_q != '0);
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/rid_credit.sv
`timescale 1ns/1ps
module rid_credit #(
  parameter int unsigned CREDIT_MAX = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic send_i,
  input  logic ret_i,
  output logic avail_o
);
  localparam int unsigned CW = $clog2(CREDIT_MAX + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CW'(CREDIT_MAX);
    else begin
      case ({ret_i, send_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign avail_o = (cnt_q != '0);
endmodule

// File: rtl/rr_input_dispatcher.sv
`timescale 1ns/1ps
module rr_input_dispatcher
  import rid_pkg::*;
#(
  parameter int unsigned NUM_PORTS  = 4,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned CREDIT_MAX = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        fixed_mode_i,
  input  logic [NUM_PORTS-1:0]        in_valid_i,
  input  logic [NUM_PORTS*DATA_W-1:0] in_data_i,
  input  logic [NUM_PORTS-1:0]        credit_i,
  output logic [NUM_PORTS-1:0]        link_valid_o,
  output logic [NUM_PORTS*DATA_W-1:0] link_data_o,
  output logic [NUM_PORTS-1:0]        overflow_o
);
  localparam int unsigned IDX_W = idx_width(NUM_PORTS);

  disp_mode_e                   mode;
  logic [IDX_W-1:0]             sel   [NUM_PORTS];
  logic [IDX_W-1:0]             tgt   [NUM_PORTS];
  logic [DATA_W-1:0]            head  [NUM_PORTS];
  logic [NUM_PORTS-1:0]         fifo_nonempty;
  logic [NUM_PORTS-1:0]         link_avail;
  logic [NUM_PORTS-1:0]         pop;
  logic [NUM_PORTS*IDX_W-1:0]   sel_flat;

  assign mode = fixed_mode_i ? MODE_FIXED : MODE_ROTATE;

  for (genvar r = 0; r < NUM_PORTS; r++) begin : g_q
    rid_selector #(
      .NUM(NUM_PORTS), .START(r), .IDX_W(IDX_W)
    ) u_sel (
      .clk_i(clk_i), .rst_ni(rst_ni), .sel_o(sel[r])
    );

    rid_fifo #(
      .DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)
    ) u_fifo (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .push_i(in_valid_i[r]),
      .din_i (in_data_i[r*DATA_W +: DATA_W]),
      .pop_i (pop[r]),
      .head_o(head[r]),
      .busy_o(fifo_nonempty[r]),
      .ovf_o (overflow_o[r])
    );

    rid_credit #(
      .CREDIT_MAX(CREDIT_MAX)
    ) u_cred (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .send_i (link_valid_o[r]),
      .ret_i  (credit_i[r]),
      .avail_o(link_avail[r])
    );

    assign tgt[r] = (mode == MODE_FIXED) ? IDX_W'(r) : sel[r];
    assign pop[r] = fifo_nonempty[r] && link_avail[tgt[r]];
    assign sel_flat[r*IDX_W +: IDX_W] = sel[r];
  end

  // Per-link mux: selectors are distinct, so at most one queue hits a link.
  always_comb begin
    link_valid_o = '0;
    link_data_o  = '0;
    for (int l = 0; l < NUM_PORTS; l++) begin
      for (int r = 0; r < NUM_PORTS; r++) begin
        if (pop[r] && (tgt[r] == IDX_W'(l))) begin
          link_valid_o[l]                  = 1'b1;
          link_data_o[l*DATA_W +: DATA_W]  = head[r];
        end
      end
    end
  end
endmodule

// File: rtl/rr_input_dispatcher_chk.sv
`timescale 1ns/1ps
module rr_input_dispatcher_chk #(
  parameter int unsigned NUM_PORTS  = 4,
  parameter int unsigned CREDIT_MAX = 2,
  parameter int unsigned IDX_W      = 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       fixed_mode_i,
  input logic [NUM_PORTS-1:0]       link_valid_o,
  input logic [NUM_PORTS-1:0]       credit_i,
  input logic [NUM_PORTS-1:0]       overflow_o,
  input logic [NUM_PORTS*IDX_W-1:0] sel_flat_i,
  input logic [NUM_PORTS-1:0]       fifo_busy_i
);
  localparam int unsigned OW = $clog2(CREDIT_MAX + 2);

  logic [NUM_PORTS-1:0] sel_mask;

  always_comb begin
    sel_mask = '0;
    for (int r = 0; r < NUM_PORTS; r++)
      sel_mask = sel_mask | (NUM_PORTS'(1) << sel_flat_i[r*IDX_W +: IDX_W]);
  end

  function automatic logic [IDX_W-1:0] step_idx(logic [IDX_W-1:0] v);
    return (v == IDX_W'(NUM_PORTS - 1)) ? '0 : v + 1'b1;
  endfunction

  // R2: selectors cover every link, hence pairwise distinct
  a_r2_distinct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &sel_mask);

  for (genvar l = 0; l < NUM_PORTS; l++) begin : g_chk
    logic [OW-1:0] outst_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) outst_q <= '0;
      else if (link_valid_o[l] && !(credit_i[l] && outst_q != '0)) outst_q <= outst_q + 1'b1;
      else if (!link_valid_o[l] && credit_i[l] && outst_q != '0)  outst_q <= outst_q - 1'b1;
    end

    // R3: selector moves by one every cycle
    a_r3_rotate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_ni |=> (sel_flat_i[l*IDX_W +: IDX_W] == step_idx($past(sel_flat_i[l*IDX_W +: IDX_W]))));

    // R5: never send beyond the downstream credit
    a_r5_credit_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      link_valid_o[l] |-> (outst_q < OW'(CREDIT_MAX)));

    // R6: fixed mode link l is fed only by queue l
    a_r6_fixed_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fixed_mode_i && link_valid_o[l]) |-> fifo_busy_i[l]);

    // R7: overflow flag is sticky
    a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      overflow_o[l] |=> overflow_o[l]);
  end
endmodule

bind rr_input_dispatcher rr_input_dispatcher_chk #(
  .NUM_PORTS(NUM_PORTS), .CREDIT_MAX(CREDIT_MAX), .IDX_W(IDX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fixed_mode_i(fixed_mode_i),
  .link_valid_o(link_valid_o),
  .credit_i    (credit_i),
  .overflow_o  (overflow_o),
  .sel_flat_i  (sel_flat),
  .fifo_busy_i (fifo_nonempty)
);

// File: tb/rr_input_dispatcher_tb.sv
`timescale 1ns/1ps
module rr_input_dispatcher_tb;
  localparam int M = 4;
  localparam int W = 16;
  localparam int D = 4;
  localparam int C = 2;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           fixed_mode_i = 1'b0;
  logic [M-1:0]   in_valid_i = '0;
  logic [M*W-1:0] in_data_i = '0;
  logic [M-1:0]   credit_i = '0;
  logic [M-1:0]   link_valid_o;
  logic [M*W-1:0] link_data_o;
  logic [M-1:0]   overflow_o;

  rr_input_dispatcher #(.NUM_PORTS(M), .DATA_W(W), .FIFO_DEPTH(D), .CREDIT_MAX(C)) u_dut (.*);

  always #10 clk_i = ~clk_i;

  int n_vec = 0, n_err = 0;
  bit done = 0;

  // bench model
  logic [W-1:0] m_mem [M][D];
  int m_head [M], m_cnt [M], m_cred [M], slot;
  logic m_ovf [M];
  logic [W-1:0] pkt_id = 16'h1000;

  function automatic int exp_link(int r, logic fx, int s);
    return fx ? r : (r + s) % M;
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h (slot %0d)", tag, got, exp, slot);
    end
  endtask

  task automatic step(string tag, logic [M-1:0] wv, logic [M-1:0] cr, logic fx);
    logic [M-1:0] ev;
    logic [W-1:0] ed [M];
    logic [M*W-1:0] wd;
    wd = '0;
    for (int r = 0; r < M; r++) begin
      pkt_id = pkt_id + 1;
      wd[r*W +: W] = pkt_id;
    end
    in_valid_i = wv; in_data_i = wd; credit_i = cr; fixed_mode_i = fx;
    #1;
    ev = '0;
    for (int l = 0; l < M; l++) ed[l] = '0;
    for (int r = 0; r < M; r++) begin
      int t;
      t = exp_link(r, fx, slot);
      if (m_cnt[r] > 0 && m_cred[t] > 0) begin
        ev[t] = 1'b1;
        ed[t] = m_mem[r][m_head[r]];
      end
    end
    for (int l = 0; l < M; l++) begin
      chk({tag, " valid"}, 64'(link_valid_o[l]), 64'(ev[l]));
      chk({tag, " R8 data"}, 64'(link_data_o[l*W +: W]), 64'(ed[l]));
      chk({tag, " R7 ovf"}, 64'(overflow_o[l]), 64'(m_ovf[l]));
    end
    for (int l = 0; l < M; l++) m_cred[l] = m_cred[l] + int'(cr[l]) - int'(ev[l]);
    for (int r = 0; r < M; r++) begin
      logic popd;
      popd = ev[exp_link(r, fx, slot)];
      if (wv[r]) begin
        if (m_cnt[r] == D) m_ovf[r] = 1'b1;
        else begin
          m_mem[r][(m_head[r] + m_cnt[r]) % D] = wd[r*W +: W];
          m_cnt[r]++;
        end
      end
      if (popd) begin
        m_head[r] = (m_head[r] + 1) % D;
        m_cnt[r]--;
      end
    end
    slot++;
    @(negedge clk_i);
  endtask

  function automatic logic [M-1:0] rand_credit();
    logic [M-1:0] cr;
    cr = '0;
    for (int l = 0; l < M; l++)
      if (m_cred[l] < C && ($urandom % 3) != 0) cr[l] = 1'b1;
    return cr;
  endfunction

  initial begin
    void'($urandom(32'h5eed_0417));
    for (int r = 0; r < M; r++) begin
      m_head[r] = 0; m_cnt[r] = 0; m_cred[r] = C; m_ovf[r] = 1'b0;
    end
    slot = 0;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1 valid", 64'(link_valid_o), 64'(0));
    chk("R1 ovf", 64'(overflow_o), 64'(0));
    chk("R1 data", 64'(link_data_o), 64'(0));
    rst_ni = 1'b1;

    // R2/R4: one packet on queue 0, then a burst on queue 2
    step("R2", 4'b0001, 4'b0000, 1'b0);
    step("R2", 4'b0100, 4'b0000, 1'b0);
    step("R4", 4'b0100, 4'b0000, 1'b0);
    step("R4", 4'b0100, 4'b0000, 1'b0);
    repeat (3) step("R4", 4'b0000, rand_credit(), 1'b0);

    // R5/R6: fixed mode, queue 0 drains its credit and stalls
    repeat (4) step("R6", 4'b0001, 4'b0000, 1'b1);
    repeat (3) step("R5", 4'b0000, 4'b0000, 1'b1);
    step("R5", 4'b0000, 4'b0001, 1'b1);
    step("R5", 4'b0000, 4'b0000, 1'b1);
    // R3: switch back while heads are stalled; rotation continued meanwhile
    repeat (4) step("R3", 4'b0000, 4'b0000, 1'b0);

    // R7: hammer queue 1 with no credit returns
    repeat (8) step("R7", 4'b0010, 4'b0000, 1'b1);
    repeat (8) step("R7", 4'b0000, rand_credit(), 1'b1);

    // random mix
    begin
      logic fx;
      fx = 1'b0;
      for (int i = 0; i < 3000; i++) begin
        if (($urandom % 150) == 0) fx = ~fx;
        step("R2/R3/R5/R6", 4'($urandom), rand_credit(), fx);
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog R1: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule